// File: doc/BRIEF.md
# Mode-Selectable DPLL Loop Filter

This block is the low-pass stage of a digital phase-locked loop. It sits between the slope-limited phase error and the controlled oscillator. On each update strobe it takes one signed phase-error sample and returns a signed frequency-correction word. That word is the sum of two terms: a proportional term, which is the error shifted right, and a saturating integrator, which accumulates a more strongly shifted copy of the error. Because the error reaching the filter is already normalised, one set of coefficients serves every supported reference rate (8 kHz, 1.544 MHz, 2.048 MHz and 19.44 MHz).

A single mode bit sets the cutoff. SONET operation gives a very low cutoff, near 70 mHz. SDH operation gives a cutoff near 1.1 Hz, and it gets there by using right shifts four bits smaller, which is roughly the ratio of the two cutoffs. A freeze input is used for holdover. It keeps the learned frequency in the integrator and removes the proportional kick. The mode can change during operation without disturbing the integrator, so the correction word does not jump.

Top module: `dpll_loop_filter`

## Requirements
- R1: While reset is asserted, and once it has been released until the first update, the correction output is zero and the integrator is zero.
- R2: On an update strobe with freeze low, the integrator adds the error (sign-extended) arithmetically shifted right by the integral shift of the current mode. The shift rounds toward minus infinity.
- R3: With mode_i = 0 (SONET), the output registered at an update is sat(new integrator + (error >>> KP_SONET)), and the integral shift is KI_SONET. The output is visible from the clock edge that samples the strobe.
- R4: With mode_i = 1 (SDH), both shifts are SDH_DELTA smaller than the SONET shifts, and R3 otherwise applies unchanged.
- R5: The integrator clamps at the signed full-scale limits of ACC_W bits (+2^(ACC_W-1)-1 and -2^(ACC_W-1)) and never wraps.
- R6: The correction output clamps at the same signed full-scale limits and never wraps.
- R7: On an update with freeze high, the integrator keeps its value and the proportional term is zero, so the output equals the held integrator.
- R8: Without an update strobe, the output and the integrator keep their values whatever the error, mode and freeze inputs do.
- R9: A change of mode keeps the integrator contents. The next update continues from the same integrator value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_i | input | 1 | Update strobe, one cycle per error sample |
| err_i | input | ERR_W | Signed, slope-limited phase error |
| mode_i | input | 1 | 0 = SONET (low cutoff), 1 = SDH (higher cutoff) |
| freeze_i | input | 1 | Holdover freeze: hold the integrator and zero the proportional term |
| corr_o | output | ACC_W | Signed frequency-correction word |

## Verification
Every result registers at the clock edge that samples the strobe, so the correction is due one edge after the strobe is driven. The bench drives inputs on falling edges and reads the output at the next falling edge. The integrator has no port of its own. It is observed one update later, through a strobe with zero error or a frozen strobe, when the output must equal it exactly. Hold behaviour is checked one idle cycle after the inputs are scrambled. The reset value is read while reset is asserted and again after the synchroniser has released it.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef enum logic {
    NET_SONET = 1'b0,
    NET_SDH   = 1'b1
  } net_mode_e;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/dlf_gain_path.sv
module dlf_gain_path
  import dlf_pkg::*;
#(
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned KP_SONET  = 10,
  parameter int unsigned KI_SONET  = 18,
  parameter int unsigned SDH_DELTA = 4
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  net_mode_e               mode_i,
  input  logic                    freeze_i,
  output logic signed [ACC_W-1:0] prop_o,
  output logic signed [ACC_W-1:0] intg_o
);
  localparam int unsigned EXT_W  = ACC_W - ERR_W;
  localparam int unsigned KP_SDH = KP_SONET - SDH_DELTA;
  localparam int unsigned KI_SDH = KI_SONET - SDH_DELTA;

  logic signed [ACC_W-1:0] err_ext;
  logic signed [ACC_W-1:0] prop_sonet, prop_sdh, intg_sonet, intg_sdh;

  assign err_ext    = {{EXT_W{err_i[ERR_W-1]}}, err_i};
  assign prop_sonet = err_ext >>> KP_SONET;
  assign prop_sdh   = err_ext >>> KP_SDH;
  assign intg_sonet = err_ext >>> KI_SONET;
  assign intg_sdh   = err_ext >>> KI_SDH;

  always_comb begin
    if (freeze_i) begin
      prop_o = '0;
    end else if (mode_i == NET_SDH) begin
      prop_o = prop_sdh;
    end else begin
      prop_o = prop_sonet;
    end
    intg_o = (mode_i == NET_SDH) ? intg_sdh : intg_sonet;
  end
endmodule

// File: rtl/dlf_integrator.sv
module dlf_integrator #(
  parameter int unsigned ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    freeze_i,
  input  logic signed [ACC_W-1:0] inc_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_next_o
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W:0]   sum;
  logic                    acc_en;

  assign sum    = {acc_q[ACC_W-1], acc_q} + {inc_i[ACC_W-1], inc_i};
  assign acc_en = en_i && !freeze_i;

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) begin
      acc_d = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o      = acc_q;
  assign acc_next_o = acc_en ? acc_d : acc_q;

  assert_acc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  assert_acc_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && freeze_i) |=> $stable(acc_q));
  assert_no_wrap_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && !inc_i[ACC_W-1] && !acc_q[ACC_W-1]) |=> !acc_q[ACC_W-1]);
  assert_no_wrap_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && inc_i[ACC_W-1] && acc_q[ACC_W-1]) |=> acc_q[ACC_W-1]);
endmodule

// File: rtl/dlf_out_stage.sv
module dlf_out_stage #(
  parameter int unsigned ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] acc_next_i,
  input  logic signed [ACC_W-1:0] prop_i,
  output logic signed [ACC_W-1:0] corr_o
);
  localparam logic signed [ACC_W-1:0] OUT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] corr_q, corr_d;
  logic signed [ACC_W:0]   sum;

  assign sum = {acc_next_i[ACC_W-1], acc_next_i} + {prop_i[ACC_W-1], prop_i};

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) begin
      corr_d = sum[ACC_W] ? OUT_MIN : OUT_MAX;
    end else begin
      corr_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= '0;
    end else if (en_i) begin
      corr_q <= corr_d;
    end
  end

  assign corr_o = corr_q;

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(corr_q));
  assert_out_no_wrap_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !prop_i[ACC_W-1] && !acc_next_i[ACC_W-1]) |=> !corr_q[ACC_W-1]);
  assert_out_no_wrap_dn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && prop_i[ACC_W-1] && acc_next_i[ACC_W-1]) |=> corr_q[ACC_W-1]);
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
  import dlf_pkg::*;
#(
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned KP_SONET  = 10,
  parameter int unsigned KI_SONET  = 18,
  parameter int unsigned SDH_DELTA = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    mode_i,
  input  logic                    freeze_i,
  output logic signed [ACC_W-1:0] corr_o
);
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_n_s;
  logic signed [ACC_W-1:0]    prop, intg, acc, acc_next;
  net_mode_e                  mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[RST_SYNC_STAGES-1];
  assign mode    = net_mode_e'(mode_i);

  dlf_gain_path #(
    .ERR_W(ERR_W), .ACC_W(ACC_W), .KP_SONET(KP_SONET),
    .KI_SONET(KI_SONET), .SDH_DELTA(SDH_DELTA)
  ) u_gain (
    .err_i(err_i), .mode_i(mode), .freeze_i(freeze_i),
    .prop_o(prop), .intg_o(intg)
  );

  dlf_integrator #(.ACC_W(ACC_W)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_n_s), .en_i(upd_i), .freeze_i(freeze_i),
    .inc_i(intg), .acc_o(acc), .acc_next_o(acc_next)
  );

  dlf_out_stage #(.ACC_W(ACC_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_n_s), .en_i(upd_i),
    .acc_next_i(acc_next), .prop_i(prop), .corr_o(corr_o)
  );

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_n_s |-> (corr_o == '0 && acc == '0));
  assert_freeze_out_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (upd_i && freeze_i) |=> corr_o == $past(acc));
  assert_mode_keeps_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!upd_i && mode_i != $past(mode_i)) |=> $stable(acc));
endmodule

// File: tb/dpll_loop_filter_tb.sv
module dpll_loop_filter_tb;
  localparam int ERR_W = 12;
  localparam int ACC_W = 14;
  localparam int KP_S  = 6;
  localparam int KI_S  = 8;
  localparam int DELTA = 4;
  localparam int LIM_HI = (1 << (ACC_W-1)) - 1;
  localparam int LIM_LO = -(1 << (ACC_W-1));

  logic clk_i = 1'b0;
  logic rst_ni;
  logic upd_i;
  logic signed [ERR_W-1:0] err_i;
  logic mode_i;
  logic freeze_i;
  logic signed [ACC_W-1:0] corr_o;

  int checks = 0;
  int fails  = 0;
  int m_int  = 0;
  int m_out  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dpll_loop_filter #(
    .ERR_W(ERR_W), .ACC_W(ACC_W), .KP_SONET(KP_S),
    .KI_SONET(KI_S), .SDH_DELTA(DELTA)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .err_i(err_i),
    .mode_i(mode_i), .freeze_i(freeze_i), .corr_o(corr_o)
  );

  function automatic int clamp(int v);
    if (v > LIM_HI) return LIM_HI;
    if (v < LIM_LO) return LIM_LO;
    return v;
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(corr_o) != exp) begin
      fails++;
      $display("FAIL %s: corr_o actual %0d expected %0d", tag, int'(corr_o), exp);
    end
  endtask

  task automatic strobe(string tag, int e, bit m, bit f);
    int kp, ki;
    @(negedge clk_i);
    err_i = ERR_W'(e); mode_i = m; freeze_i = f; upd_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0;
    kp = m ? KP_S - DELTA : KP_S;
    ki = m ? KI_S - DELTA : KI_S;
    if (!f) m_int = clamp(m_int + (e >>> ki));
    m_out = clamp(m_int + (f ? 0 : (e >>> kp)));
    check(tag, m_out);
  endtask

  task automatic idle_check(string tag, int e, bit m, bit f);
    @(negedge clk_i);
    err_i = ERR_W'(e); mode_i = m; freeze_i = f; upd_i = 1'b0;
    @(negedge clk_i);
    check(tag, m_out);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; upd_i = 1'b0; err_i = '0; mode_i = 1'b0; freeze_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1", 0);

    // R3 / R4 sweeps over the full error range in both modes, R2 via zero-error strobes
    for (int m = 0; m < 2; m++) begin
      int n = 0;
      for (int e = -(1 << (ERR_W-1)); e < (1 << (ERR_W-1)); e += 29) begin
        strobe(m ? "R4" : "R3", e, m[0], 1'b0);
        n++;
        if (n % 7 == 0) strobe("R2", 0, m[0], 1'b0);
        if (n % 11 == 0) idle_check("R8", -e, ~m[0], n[0]);
        if (n % 13 == 0) strobe("R7", e, m[0], 1'b1);
      end
    end

    // R9: mode flips keep the integrator
    strobe("R9", 1000, 1'b1, 1'b0);
    idle_check("R9", 0, 1'b0, 1'b0);
    strobe("R9", 0, 1'b0, 1'b1);
    strobe("R9", 0, 1'b1, 1'b0);

    // R5 / R6: drive to positive then negative full scale
    for (int k = 0; k < 120; k++) strobe("R5", 2047, 1'b1, 1'b0);
    strobe("R6", 2047, 1'b1, 1'b0);
    strobe("R5", 0, 1'b0, 1'b1);
    for (int k = 0; k < 200; k++) strobe("R5", -2048, 1'b1, 1'b0);
    strobe("R6", -2048, 1'b1, 1'b0);
    strobe("R5", 0, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) strobe("R7", 2047, 1'b0, 1'b1);
    idle_check("R8", 1234, 1'b1, 1'b0);

    // R1: reset mid-run clears state
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    m_int = 0; m_out = 0;
    check("R1", 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    strobe("R1", 0, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule